// File: doc/BRIEF.md
# Device Identifier Fuse Readout Registers

This block is a small memory-mapped peripheral that holds a fixed 128-bit device identifier and lets software read it one 32-bit word at a time. The identifier arrives on a constant input. The peripheral claims a 1 KiB address window and exposes two registers in it: a command register and a result register.

To fetch a word, software writes the command register. The write only fetches when two conditions hold: the arm bit (bit 1) is set, and at least one bit of the unlock mask 0xAC00 is set. In that case the upper half of the written word is a byte offset into the identifier. If the offset is 12 or less, four identifier bytes are copied into the result register, most significant byte first. Every command write stores the written word with the arm bit forced to zero. The result register cannot be written, and all other offsets read as zero.

Top module: `devid_fuse_regs`

## Requirements
- R1: After reset, reads of both the command register (offset 0x040) and the result register (offset 0x060) return zero. Read data is zero while reset is asserted.
- R2: A write to offset 0x040 stores the written word with bit 1 cleared. A later read of 0x040 returns that stored word, so bit 1 always reads 0.
- R3: A command write updates the result register only if bit 1 is set and at least one bit of the mask 0xAC00 is set. If either condition is missing, the result register keeps its value.
- R4: The byte offset is bits [31:16] of the command word. An offset above 12 leaves the result register unchanged, even when R3's condition holds.
- R5: On a fetch, identifier byte k is bits [127-8k:120-8k] of the identifier input. The result register is set to {byte[off], byte[off+1], byte[off+2], byte[off+3]}, with byte[off] in bits [31:24].
- R6: Writes to offset 0x060 have no effect on either register.
- R7: Reads at any 10-bit offset other than 0x040 and 0x060 return zero. Writes at such offsets change no register.
- R8: Read data appears in the cycle after the read enable and is zero when no read was requested. A register written on one clock edge is returned by a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ident | input | 128 | Device identifier; byte 0 in bits [127:120] |
| addr | input | 10 | Byte offset within the 1 KiB window |
| wr_en | input | 1 | Write strobe, one 32-bit access per cycle |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, one cycle after rd_en |

## Verification
The assertions assume that `ident` is held constant, that `addr` is word-aligned, and that a read and a write do not share a cycle. The bench holds the identifier fixed for the whole run. It issues each access on its own cycle and uses only aligned offsets. Within those limits, the stimulus sweeps every offset from 0 to 15 under each single bit of the unlock mask. It also covers commands missing either trigger condition, out-of-range and very large offsets, writes to the result register and to unmapped offsets, back-to-back write and read, and a reset in mid-run.

// File: rtl/devid_fuse_regs.sv
module devid_fuse_regs #(
  parameter logic [9:0]  CMD_OFS   = 10'h040,
  parameter logic [9:0]  KEY_OFS   = 10'h060,
  parameter logic [31:0] UNLOCK    = 32'h0000_AC00,
  parameter int          ARM_BIT   = 1,
  parameter int          ID_BYTES  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [127:0] ident,
  input  logic [9:0]   addr,
  input  logic         wr_en,
  input  logic [31:0]  wr_data,
  input  logic         rd_en,
  output logic [31:0]  rd_data
);
  localparam int MAX_OFS = ID_BYTES - 4;

  logic [31:0] cmd_q, key_q, pick, rd_mux;
  logic [15:0] ofs;
  logic        cmd_wr, fire;

  assign ofs    = wr_data[31:16];
  assign cmd_wr = wr_en && (addr == CMD_OFS);
  assign fire   = cmd_wr && wr_data[ARM_BIT] && |(wr_data & UNLOCK) && (ofs <= 16'(MAX_OFS));
  assign pick   = 32'(ident >> (7'd96 - {ofs[3:0], 3'b000}));
  assign rd_mux = (addr == CMD_OFS) ? cmd_q : (addr == KEY_OFS) ? key_q : 32'h0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q <= '0;
      key_q <= '0;
    end else begin
      if (cmd_wr) cmd_q <= wr_data & ~(32'h1 << ARM_BIT);
      if (fire)   key_q <= pick;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_en ? rd_mux : 32'h0;

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_data == 32'h0));

  assert_arm_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == CMD_OFS) |=> (rd_data[ARM_BIT] == 1'b0));

  assert_no_trigger_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CMD_OFS && !(wr_data[ARM_BIT] && |(wr_data & UNLOCK))) |=> $stable(key_q));

  assert_range_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CMD_OFS && wr_data[31:16] > 16'(MAX_OFS)) |=> $stable(key_q));

  assert_key_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == KEY_OFS) |=> ($stable(key_q) && $stable(cmd_q)));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != CMD_OFS && addr != KEY_OFS) |=> (rd_data == 32'h0));

  assert_key_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == KEY_OFS) |=> (rd_data == $past(key_q)));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == 32'h0));
endmodule

// File: tb/sim_devid_fuse_regs.sv
module sim_devid_fuse_regs;
  logic         clk = 0, rst_n = 0;
  logic [127:0] ident = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
  logic [9:0]   addr = '0;
  logic         wr_en = 0, rd_en = 0;
  logic [31:0]  wr_data = '0, rd_data;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string req = "R1";

  logic [31:0] m_cmd = 0, m_key = 0, m_rd = 0;

  devid_fuse_regs u0 (.clk(clk), .rst_n(rst_n), .ident(ident), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  always #5 clk = ~clk;

  function automatic logic [7:0] idbyte(int k);
    return ident[127 - 8*k -: 8];
  endfunction

  always @(posedge clk) begin
    logic [31:0] nrd;
    int off;
    if (!rst_n) begin
      m_cmd = 0; m_key = 0; m_rd = 0;
    end else begin
      nrd = 0;
      if (rd_en) begin
        if (addr == 10'h040) nrd = m_cmd;
        else if (addr == 10'h060) nrd = m_key;
      end
      if (wr_en && addr == 10'h040) begin
        off = int'(wr_data[31:16]);
        if (wr_data[1] && (wr_data & 32'hAC00) != 0 && off <= 12)
          m_key = {idbyte(off), idbyte(off+1), idbyte(off+2), idbyte(off+3)};
        m_cmd = wr_data & ~32'h2;
      end
      m_rd = nrd;
    end
  end

  always @(negedge clk) if (!done) begin
    compared++;
    if (rd_data !== m_rd) begin
      mismatched++;
      $display("FAIL %s: rd_data=%h expected %h at %0t", req, rd_data, m_rd, $time);
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic both();
    rd(10'h040); rd(10'h060);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; both();
    req = "R5"; wr(10'h040, 32'h0000_AC02); both();
    req = "R2"; wr(10'h040, 32'hFFFF_FFFF); rd(10'h040);
    req = "R5"; wr(10'h040, 32'h000C_0402); both();
    req = "R4"; wr(10'h040, 32'h000D_AC02); both();
    wr(10'h040, 32'h0100_8002); both();
    wr(10'h040, 32'hFFFF_AC02); both();
    req = "R3"; wr(10'h040, 32'h0005_5002); both();
    wr(10'h040, 32'h0005_AC00); both();
    wr(10'h040, 32'h0006_0800); both();
    req = "R6"; wr(10'h060, 32'hDEAD_BEEF); both();
    req = "R7"; rd(10'h044); rd(10'h3FC); rd(10'h000);
    wr(10'h044, 32'h0003_AC02); wr(10'h3FC, 32'h1234_5678); both();
    req = "R8";
    @(negedge clk); addr = 10'h040; wr_data = 32'h0002_2002; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 10'h060; rd_en = 1;
    @(negedge clk); rd_en = 0;
    repeat (2) @(negedge clk);
    req = "R5";
    for (int o = 0; o < 16; o++)
      for (int b = 0; b < 4; b++) begin
        logic [31:0] mk;
        mk = (b == 0) ? 32'h0400 : (b == 1) ? 32'h0800 : (b == 2) ? 32'h2000 : 32'h8000;
        wr(10'h040, (32'(o) << 16) | mk | 32'h2);
        both();
      end
    req = "R1";
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    both();
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule